// File: doc/BRIEF.md
# AES-128 Round Key Expansion Engine

This block turns a 128-bit cipher key into the full set of eleven AES-128 round keys and keeps them in an addressed table. A one-cycle start pulse loads the key; on that clock edge the key itself is written to table entry 0, and on each of the following ten edges one further round key is computed from the previous one by purely combinational logic, written into the next table entry and held in a step register for the next step. Generation therefore occupies eleven clock edges in total.

A decryption datapath consumes the table through an independent read port. It normally walks the entries from 10 down to 0, which is why all keys are computed ahead of time rather than derived on the fly. An end-of-conversion flag tells the consumer that the table is complete and stays high until the next start. A start that arrives mid-run abandons the current expansion and begins again with the new key.

Top module: `rkx_top`

## Requirements
- R1: After reset, `busy` and `eoc` are 0 and every table entry reads as all zeros.
- R2: The clock edge that samples `start` = 1 writes `cipherKey` unchanged into table entry 0.
- R3: Entry k (1..10) holds AES-128 round key k. Word 0 is bits [127:96]. The new word 0 is SubWord(RotWord(previous word 3)) XOR rcon(k) XOR previous word 0. RotWord moves each byte up one place, so the top byte wraps to the bottom. The round constants for k = 1..10 are 01,02,04,08,10,20,40,80,1b,36, placed in bits [31:24]. Each later word is the preceding new word XOR the same-position word of the previous key.
- R4: After the start edge, `busy` is 1 and `eoc` is 0 for the next nine cycles, and `eoc` reads 1 exactly ten cycles after the start edge, with `busy` 0 from then on.
- R5: Once set, `eoc` stays 1 until a start is sampled. The edge that samples `start` clears it.
- R6: A start sampled while `busy` is 1 restarts the expansion from the new key. Timing then follows R4 from the new start, and the table ends up holding the new key's expansion.
- R7: With the default READ_LAT = 1, `rdKey` shows the entry addressed by `rdAddr` one clock edge after the address is applied, and does not change before that edge. With READ_LAT = 0 it is combinational.
- R8: Read addresses 11 to 15 return all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that loads `cipherKey` and begins expansion |
| cipherKey | input | 128 | Cipher key, word 0 in bits [127:96] |
| busy | output | 1 | Expansion in progress |
| eoc | output | 1 | End of conversion: the table holds all eleven keys |
| rdAddr | input | 4 | Table read address |
| rdKey | output | 128 | Table read data |

## Verification
The hardest situation to reach from the ports is a restart in the middle of an expansion. In that case the step register and the counter must drop a half-built sequence, and the partly filled table must be fully overwritten. The bench starts one key, pulses start with a second key four cycles later, and then checks the end-of-conversion timing against the second pulse and every table entry against a reference expansion of the second key. The bench builds its reference S-box with a generator walk of the field, independently of the design's inversion logic, and checks it against published round-key values.

// File: rtl/rkx_pkg.sv
package rkx_pkg;

  localparam int KEY_W  = 128;
  localparam int WORD_W = 32;
  localparam int WORDS  = KEY_W / WORD_W;
  localparam int ADDR_W = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadKey;  // take the external key into entry 0
    logic              stepKey;  // store the next computed key
    logic [ADDR_W-1:0] wrAddr;   // table entry to write
    logic [ADDR_W-1:0] step;     // round index used for the round constant
  } rkxStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // Multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gfMul(r, base);
      base = gfMul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] sboxFwd(input logic [7:0] a);
    logic [7:0] v;
    v = gfInv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] roundConst(input logic [ADDR_W-1:0] step);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < (1 << ADDR_W); i++) begin
      if (i < int'(step)) r = xtime(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/rkx_ctrl.sv
module rkx_ctrl
  import rkx_pkg::*;
#(
  parameter int NUM_KEYS = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output rkxStrobes_t strobes,
  output logic        busy,
  output logic        eoc
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_KEYS - 1);

  logic [ADDR_W-1:0] stepCount;

  always_comb begin
    strobes.loadKey = start;
    strobes.stepKey = busy && !start;
    strobes.wrAddr  = start ? '0 : stepCount;
    strobes.step    = stepCount;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      eoc       <= 1'b0;
      stepCount <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      eoc       <= 1'b0;
      stepCount <= ADDR_W'(1);
    end else if (busy) begin
      if (stepCount == LAST_IDX) begin
        busy <= 1'b0;
        eoc  <= 1'b1;
      end
      stepCount <= stepCount + 1'b1;
    end
  end

endmodule

// File: rtl/rkx_path.sv
module rkx_path
  import rkx_pkg::*;
#(
  parameter int NUM_KEYS = 11,
  parameter int READ_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rkxStrobes_t       strobes,
  input  logic [KEY_W-1:0]  cipherKey,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [KEY_W-1:0]  rdKey
);

  logic [KEY_W-1:0]  stepReg;
  logic [KEY_W-1:0]  muxKey;
  logic [KEY_W-1:0]  nextKey;
  logic [KEY_W-1:0]  wrData;
  logic [WORD_W-1:0] prevWord [WORDS];
  logic [WORD_W-1:0] newWord  [WORDS];
  logic [WORD_W-1:0] lastWord;
  logic [WORD_W-1:0] rotWord;
  logic [WORD_W-1:0] subWord;
  logic [KEY_W-1:0]  keyTable [NUM_KEYS];
  logic [KEY_W-1:0]  rdSel;

  // Source select: external key on load, fed-back key otherwise
  assign muxKey = strobes.loadKey ? cipherKey : stepReg;

  // Split into words, word 0 at the top
  for (genvar w = 0; w < WORDS; w++) begin : g_split
    assign prevWord[w] = muxKey[KEY_W-1-w*WORD_W -: WORD_W];
  end

  assign lastWord = prevWord[WORDS-1];
  assign rotWord  = {lastWord[WORD_W-9:0], lastWord[WORD_W-1 -: 8]};

  for (genvar b = 0; b < WORD_W / 8; b++) begin : g_sub
    assign subWord[b*8 +: 8] = sboxFwd(rotWord[b*8 +: 8]);
  end

  assign newWord[0] = subWord ^ {roundConst(strobes.step), {(WORD_W-8){1'b0}}} ^ prevWord[0];

  for (genvar w = 1; w < WORDS; w++) begin : g_chain
    assign newWord[w] = newWord[w-1] ^ prevWord[w];
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_join
    assign nextKey[KEY_W-1-w*WORD_W -: WORD_W] = newWord[w];
  end

  assign wrData = strobes.loadKey ? muxKey : nextKey;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepReg <= '0;
    end else if (strobes.loadKey || strobes.stepKey) begin
      stepReg <= wrData;
    end
  end

  // Key table, one register per entry
  for (genvar e = 0; e < NUM_KEYS; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keyTable[e] <= '0;
      end else if ((strobes.loadKey || strobes.stepKey) &&
                   (strobes.wrAddr == ADDR_W'(e))) begin
        keyTable[e] <= wrData;
      end
    end
  end

  always_comb begin
    rdSel = '0;
    for (int e = 0; e < NUM_KEYS; e++) begin
      if (rdAddr == ADDR_W'(e)) rdSel = keyTable[e];
    end
  end

  if (READ_LAT == 0) begin : g_rd_comb
    assign rdKey = rdSel;
  end else begin : g_rd_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdKey <= '0;
      else        rdKey <= rdSel;
    end
  end

endmodule

// File: rtl/rkx_top.sv
module rkx_top
  import rkx_pkg::*;
#(
  parameter int NUM_KEYS = 11,
  parameter int READ_LAT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] cipherKey,
  output logic         busy,
  output logic         eoc,
  input  logic [3:0]   rdAddr,
  output logic [127:0] rdKey
);

  rkxStrobes_t strobes;

  rkx_ctrl #(.NUM_KEYS(NUM_KEYS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .eoc     (eoc)
  );

  rkx_path #(.NUM_KEYS(NUM_KEYS), .READ_LAT(READ_LAT)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .cipherKey (cipherKey),
    .rdAddr    (rdAddr),
    .rdKey     (rdKey)
  );

endmodule

// File: rtl/rkx_checker.sv
module rkx_checker #(
  parameter int NUM_KEYS = 11,
  parameter int READ_LAT = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         eoc,
  input logic [3:0]   rdAddr,
  input logic [127:0] rdKey
);

  // Edges since the last sampled start, counting the start edge as 1
  logic [4:0] sinceStart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sinceStart <= '0;
    else if (start)             sinceStart <= 5'd1;
    else if (sinceStart != '1)  sinceStart <= sinceStart + 1'b1;
  end

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !eoc));

  assert_eoc_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> (sinceStart == 5'(NUM_KEYS)));

  assert_eoc_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> !busy);

  assert_eoc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !start) |=> eoc);

  assert_eoc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !eoc);

  if (READ_LAT == 0) begin : g_rng_comb
    assert_read_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rdAddr) >= NUM_KEYS) |-> (rdKey == '0));
  end else begin : g_rng_reg
    assert_read_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rdAddr) >= NUM_KEYS) |=> (rdKey == '0));
  end

endmodule

bind rkx_top rkx_checker #(.NUM_KEYS(NUM_KEYS), .READ_LAT(READ_LAT)) u_rkx_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .eoc    (eoc),
  .rdAddr (rdAddr),
  .rdKey  (rdKey)
);

// File: tb/test_rkx_top.sv
`timescale 1ns/1ps
module test_rkx_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] cipherKey = '0;
  logic         busy;
  logic         eoc;
  logic [3:0]   rdAddr = '0;
  logic [127:0] rdKey;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0]   sbox [256];
  logic [127:0] refKeys [11];

  // Scoreboard queues
  int           qAddr [$];
  logic [127:0] qExp  [$];
  int           qDue  [$];
  string        qTag  [$];

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  rkx_top i_rkx_top (
    .clk(clk), .rst_n(rst_n), .start(start), .cipherKey(cipherKey),
    .busy(busy), .eoc(eoc), .rdAddr(rdAddr), .rdKey(rdKey)
  );

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  // S-box by walking generator 3 and its inverse
  task automatic buildSbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sbox[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sbox[0] = 8'h63;
  endtask

  task automatic expandRef(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sbox[t[31:24]], sbox[t[23:16]], sbox[t[15:8]], sbox[t[7:0]]};
        t = t ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k < 11; k++) refKeys[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
  endtask

  // Driver: apply a read address and push the expected result
  task automatic pushRead(input int a, input string tag);
    @(negedge clk);
    rdAddr = 4'(a);
    qAddr.push_back(a);
    qExp.push_back(a < 11 ? refKeys[a] : 128'h0);
    qDue.push_back(cyc + 1);
    qTag.push_back(tag);
  endtask

  // Monitor: pop and compare once the registered read is due
  always @(negedge clk) begin
    while (qDue.size() > 0 && qDue[0] <= cyc) begin
      check(rdKey === qExp[0], $sformatf("%s read addr %0d", qTag[0], qAddr[0]),
            rdKey, qExp[0]);
      void'(qAddr.pop_front()); void'(qExp.pop_front());
      void'(qDue.pop_front());  void'(qTag.pop_front());
    end
  end

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseStart(input logic [127:0] k);
    @(negedge clk);
    start = 1'b1; cipherKey = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Called at the negedge right after the start edge; counts cycles to eoc
  task automatic waitEoc(input string tag);
    int n = 0;
    check(busy === 1'b1 && eoc === 1'b0, {tag, " busy after start"}, {busy, eoc}, 2'b10);
    while (eoc !== 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
      if (n < 10)
        check(busy === 1'b1 && eoc === 1'b0, {tag, " busy during run"}, {busy, eoc}, 2'b10);
    end
    check(n == 10, {tag, " cycles to eoc"}, n, 10);
    check(busy === 1'b0, {tag, " busy low at eoc"}, busy, 0);
  endtask

  task automatic readAll(input logic reverse);
    for (int i = 0; i < 16; i++) begin
      int a;
      a = reverse ? ((i < 11) ? 10 - i : i) : i;
      pushRead(a, a == 0 ? "R2" : (a < 11 ? "R3" : "R8"));
    end
    drain();
  endtask

  task automatic runKey(input logic [127:0] k, input logic reverse);
    expandRef(k);
    pulseStart(k);
    waitEoc("R4");
    readAll(reverse);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    buildSbox();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(busy === 1'b0 && eoc === 1'b0, "R1 flags after reset", {busy, eoc}, 0);
    expandRef(128'h0);
    for (int a = 0; a < 16; a++) begin
      qAddr.push_back(a); qExp.push_back(128'h0); qDue.push_back(cyc + 1 + a); qTag.push_back("R1");
      @(negedge clk); rdAddr = 4'(a);
    end
    // first pushed item is due before any new address; compare against zero table
    drain();

    // Known vector plus reference self-check (R3)
    expandRef(128'h2b7e151628aed2a6abf7158809cf4f3c);
    check(refKeys[1] === 128'ha0fafe1788542cb123a339392a6c7605, "R3 reference round 1",
          refKeys[1], 128'ha0fafe1788542cb123a339392a6c7605);
    check(refKeys[10] === 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R3 reference round 10",
          refKeys[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    runKey(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b1);

    // R5: eoc holds while idle
    repeat (5) @(negedge clk);
    check(eoc === 1'b1, "R5 eoc held", eoc, 1);

    // R7: registered read latency
    @(negedge clk); rdAddr = 4'd0;
    @(negedge clk); rdAddr = 4'd10;
    #1;
    check(rdKey === refKeys[0], "R7 rdKey unchanged before edge", rdKey, refKeys[0]);
    @(negedge clk);
    check(rdKey === refKeys[10], "R7 rdKey after one edge", rdKey, refKeys[10]);

    // Further key patterns; the start edge clears eoc (R5)
    expandRef(128'h0);
    pulseStart(128'h0);
    check(eoc === 1'b0, "R5 eoc cleared by start", eoc, 0);
    waitEoc("R4");
    readAll(1'b0);
    runKey({128{1'b1}}, 1'b0);
    runKey(128'h000102030405060708090a0b0c0d0e0f, 1'b1);

    // R6: restart mid-run with a different key
    pulseStart(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    repeat (3) @(negedge clk);
    expandRef(128'hdeadbeef0123456789abcdeffedcba98);
    @(negedge clk);
    start = 1'b1; cipherKey = 128'hdeadbeef0123456789abcdeffedcba98;
    @(negedge clk);
    start = 1'b0;
    waitEoc("R6");
    readAll(1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule